// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked request port and an external asynchronous static RAM of 32K eight-bit words. Each accepted request reads or writes one word. The controller turns it into a timed sequence of address, select, enable, write and output-enable levels. It also drives the shared data bus through separate out, in and output-enable signals. Every strobe leaves a flip-flop, so no pin can glitch between clock edges.

The access times are given in picoseconds along with the clock period. Each one is rounded up to a whole number of cycles, with a floor of one cycle. With a 10 ns clock the defaults give a three-cycle read wait, a two-cycle write pulse and a one-cycle write recovery. A read returns its data with a one-cycle `rsp_valid` pulse. A write has no response.

The controller has six states. `ST_IDLE` keeps the RAM deselected. `ST_READ` holds the read strobes for the access wait. `ST_TURN` is one cycle with output enable high and the bus not driven. `ST_WSETUP` presents the address and data with write enable still high. `ST_WPULSE` holds write enable low. `ST_WRECOV` holds write enable high while the address and data stay put.

The transitions are as follows:
- `ST_IDLE` goes to `ST_READ` for a read and to `ST_WSETUP` for a write.
- At the end of the read wait, `ST_READ` returns to `ST_READ` for a back-to-back read, goes to `ST_TURN` for a write, or goes to `ST_IDLE` when no request is waiting.
- `ST_TURN` goes to `ST_WSETUP` or `ST_READ`, depending on the pending operation.
- `ST_WSETUP` goes to `ST_WPULSE`, and `ST_WPULSE` goes to `ST_WRECOV` when the pulse ends.
- At the end of recovery, `ST_WRECOV` goes to `ST_WSETUP` for another write, to `ST_TURN` for a read, or to `ST_IDLE`.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held, and in `ST_IDLE`, the pins read `sram_cs_n`=1, `sram_ce`=0, `sram_we_n`=1, `sram_oe_n`=1 and `sram_dq_oe`=0, with `req_ready`=1. Whenever `sram_cs_n` is 1, the other four pins hold those idle values.
- R2: Output enable is low only while `sram_cs_n`=0, `sram_ce`=1 and `sram_we_n`=1. A read accepted in idle holds these strobes and its address for the read wait.
- R3: A write accepted in idle spends one cycle with write enable high while the address and data are driven. Write enable is then low for exactly the write-pulse cycle count, followed by the recovery cycle count with write enable high.
- R4: The address and write data do not change while write enable is low, nor on the cycle after it rises.
- R5: Between two write pulses, write enable is high for at least the recovery count plus one cycle. It is never held low across two writes.
- R6: A read accepted in the last wait cycle of a read keeps `sram_cs_n` and `sram_oe_n` low and changes only the address.
- R7: `sram_dq_oe` is never 1 while `sram_oe_n` is 0. `sram_dq_oe` rises only when `sram_oe_n` was already 1 on the previous cycle.
- R8: `req_ready` is 1 only in idle, in the last read-wait cycle and in the last recovery cycle. While `req_valid` is 0, changes on the request inputs have no effect on the RAM pins.
- R9: `rsp_valid` is a one-cycle pulse in the cycle after the last read-wait cycle. It carries `sram_dq_in` as sampled on the edge that ends the wait. It occurs only for reads, and each read produces exactly one.
- R10: Each cycle count equals ceil(time / clock period), with a minimum of 1. With the defaults, the read response appears on the fourth cycle after the accepting edge, and the write pulse lasts 2 cycles.
- R11: A write followed by a read of the same address returns the written byte, including across turnarounds in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| sram_addr | output | 15 | RAM address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_ce | output | 1 | Chip enable, active high |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Data driven toward the RAM |
| sram_dq_in | input | 8 | Data returned from the RAM |
| sram_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The assertions check, on every cycle, that the pins are consistent with each other:
- the idle pin set whenever select is high;
- the read strobe combination;
- that the data driver and output enable never overlap, and that the driver rises only after a quiet cycle;
- that the address and data hold steady under and just after the write pulse;
- the minimum low and high widths of write enable;
- the isolated response pulse.

Only the bench's scenarios can show the exact cycle counts of the read wait and the write pulse, and that data survives a write-then-read round trip. The same applies to select staying low across back-to-back reads, and to idle request inputs being ignored.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WRECOV
    } sram_state_e;

    function automatic int unsigned cycles_for(input int unsigned t_ps,
                                               input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_xfer_regs.sv
module sram_xfer_regs #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wr_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              cap,
    input  logic [DATA_W-1:0] dq_in,
    output logic              wr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rsp_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            if (load) begin
                wr_q    <= wr_in;
                addr_q  <= addr_in;
                wdata_q <= wdata_in;
            end
            rsp_q <= cap;
            if (cap)
                rdata_q <= dq_in;
        end
    end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_strobe_pkg::*;
#(
    parameter int          ADDR_W      = 15,
    parameter int          DATA_W      = 8,
    parameter int unsigned CLK_PS      = 10000,
    parameter int unsigned T_READ_PS   = 25000,
    parameter int unsigned T_WPULSE_PS = 20000,
    parameter int unsigned T_WRECOV_PS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_ce,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);
    localparam int unsigned RD_CYC  = cycles_for(T_READ_PS, CLK_PS);
    localparam int unsigned WP_CYC  = cycles_for(T_WPULSE_PS, CLK_PS);
    localparam int unsigned WR_CYC  = cycles_for(T_WRECOV_PS, CLK_PS);
    localparam int unsigned MAX_CYC = (RD_CYC > WP_CYC) ?
                                      ((RD_CYC > WR_CYC) ? RD_CYC : WR_CYC) :
                                      ((WP_CYC > WR_CYC) ? WP_CYC : WR_CYC);
    localparam int          CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    sram_state_e state, state_nxt;
    logic accept, tmr_done, tmr_load, cap, wr_q;
    logic [CNT_W-1:0] tmr_val;

    assign req_ready = (state == ST_IDLE) ||
                       (((state == ST_READ) || (state == ST_WRECOV)) && tmr_done);
    assign accept    = req_valid && req_ready;
    assign cap       = (state == ST_READ) && tmr_done;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:
                if (accept) state_nxt = req_write ? ST_WSETUP : ST_READ;
            ST_READ:
                if (tmr_done) state_nxt = accept ? (req_write ? ST_TURN : ST_READ) : ST_IDLE;
            ST_TURN:
                state_nxt = wr_q ? ST_WSETUP : ST_READ;
            ST_WSETUP:
                state_nxt = ST_WPULSE;
            ST_WPULSE:
                if (tmr_done) state_nxt = ST_WRECOV;
            ST_WRECOV:
                if (tmr_done) state_nxt = accept ? (req_write ? ST_WSETUP : ST_TURN) : ST_IDLE;
            default:
                state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Strobes are registered from the next state so they change only on edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_cs_n  <= 1'b1;
            sram_ce    <= 1'b0;
            sram_we_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
        end else begin
            unique case (state_nxt)
                ST_IDLE: begin
                    sram_cs_n <= 1'b1; sram_ce <= 1'b0; sram_we_n <= 1'b1;
                    sram_oe_n <= 1'b1; sram_dq_oe <= 1'b0;
                end
                ST_READ: begin
                    sram_cs_n <= 1'b0; sram_ce <= 1'b1; sram_we_n <= 1'b1;
                    sram_oe_n <= 1'b0; sram_dq_oe <= 1'b0;
                end
                ST_TURN: begin
                    sram_cs_n <= 1'b0; sram_ce <= 1'b1; sram_we_n <= 1'b1;
                    sram_oe_n <= 1'b1; sram_dq_oe <= 1'b0;
                end
                ST_WPULSE: begin
                    sram_cs_n <= 1'b0; sram_ce <= 1'b1; sram_we_n <= 1'b0;
                    sram_oe_n <= 1'b1; sram_dq_oe <= 1'b1;
                end
                default: begin
                    sram_cs_n <= 1'b0; sram_ce <= 1'b1; sram_we_n <= 1'b1;
                    sram_oe_n <= 1'b1; sram_dq_oe <= 1'b1;
                end
            endcase
        end
    end

    assign tmr_load = (state_nxt != state) || (cap && (state_nxt == ST_READ));

    always_comb begin
        unique case (state_nxt)
            ST_READ:   tmr_val = CNT_W'(RD_CYC - 1);
            ST_WPULSE: tmr_val = CNT_W'(WP_CYC - 1);
            ST_WRECOV: tmr_val = CNT_W'(WR_CYC - 1);
            default:   tmr_val = '0;
        endcase
    end

    sram_wait_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) xfer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .wr_in    (req_write),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .cap      (cap),
        .dq_in    (sram_dq_in),
        .wr_q     (wr_q),
        .addr_q   (sram_addr),
        .wdata_q  (sram_dq_out),
        .rdata_q  (rsp_rdata),
        .rsp_q    (rsp_valid)
    );

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_cs_n |-> (!sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe));

    // R2
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_cs_n && sram_ce && sram_we_n));

    // R3
    wpulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sram_we_n) && (WP_CYC > 1)) |=> !sram_we_n);

    // R4
    whold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> ($stable(sram_addr) && $stable(sram_dq_out)));

    // R5
    wrecov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |=> sram_we_n);

    // R6
    b2b_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n && accept && !req_write) |=> (!sram_cs_n && !sram_oe_n));

    // R7
    bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    // R7
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> $past(sram_oe_n));

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (RD_CYC > 1)) |=> !rsp_valid);
endmodule

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb_top;
    localparam int unsigned CLK_PS = 10000;
    localparam int RD_EXP = (25000 + CLK_PS - 1) / CLK_PS;
    localparam int WP_EXP = (20000 + CLK_PS - 1) / CLK_PS;
    localparam int WR_EXP = (5000 + CLK_PS - 1) / CLK_PS;
    localparam int NOPS = 9;
    // {write(1), addr(15), data(8)}; for reads the data field is the expected byte
    localparam logic [23:0] OPS [NOPS] = '{
        24'h8012A5, 24'h80133C, 24'h0012A5, 24'h00133C, 24'hC055C3,
        24'h4055C3, 24'h80120F, 24'h00120F, 24'h00015B };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic req_ready, rsp_valid, sram_cs_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0] rsp_rdata, sram_dq_out, sram_dq_in;
    logic [14:0] sram_addr;

    always #2 clk = ~clk;

    sram_strobe_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_ce(sram_ce), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
        .sram_dq_oe(sram_dq_oe));

    // Small RAM model aliased on the low address byte.
    logic [7:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    assign sram_dq_in = (!sram_cs_n && sram_ce && sram_we_n && !sram_oe_n) ?
                        mem[sram_addr[7:0]] : 8'h00;
    always @(posedge sram_we_n) if (rst_n && !sram_cs_n && sram_ce) mem[sram_addr[7:0]] = sram_dq_out;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_data [64];
    int wr_idx = 0, rd_idx = 0;
    int turn_err = 0, pw_err = 0, gap_err = 0, stab_err = 0, pulses = 0, cs_rise = 0, rsp_err = 0;
    int low_run = 0, high_run = 0;
    bit seen_pulse = 0, finished = 0;
    logic p_we = 1, p_oe = 1, p_dqoe = 0, p_cs = 1, p_rsp = 0;
    logic [14:0] p_addr = '0;
    logic [7:0] p_dq = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Pin monitor, sampled mid-cycle.
    always @(negedge clk) if (rst_n) begin
        if (sram_dq_oe && !sram_oe_n) turn_err++;
        if (sram_dq_oe && !p_dqoe && !p_oe) turn_err++;
        if (sram_cs_n && !p_cs) cs_rise++;
        if (!sram_we_n) begin
            if (p_we) begin
                if (seen_pulse && high_run < WR_EXP + 1) gap_err++;
                low_run = 1;
            end else begin
                low_run++;
                if (sram_addr != p_addr || sram_dq_out != p_dq) stab_err++;
            end
        end else begin
            if (!p_we) begin
                if (low_run != WP_EXP) pw_err++;
                if (sram_addr != p_addr || sram_dq_out != p_dq) stab_err++;
                pulses++;
                seen_pulse = 1;
                high_run = 1;
            end else high_run++;
        end
        if (rsp_valid) begin
            if (p_rsp) rsp_err++;
            if (rd_idx < wr_idx) begin
                check(rsp_rdata == exp_data[rd_idx], "R11/R9 read data", rsp_rdata, exp_data[rd_idx]);
                rd_idx++;
            end else rsp_err++;
        end
        p_we = sram_we_n; p_oe = sram_oe_n; p_dqoe = sram_dq_oe; p_cs = sram_cs_n;
        p_rsp = rsp_valid; p_addr = sram_addr; p_dq = sram_dq_out;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (R1..) actual=%0d expected<20000", cyc);
            summary();
        end
    end

    task automatic issue(input logic wr, input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (!wr) begin exp_data[wr_idx] = d; wr_idx++; end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 50 && rd_idx < wr_idx; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int n, snap, bad;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(sram_cs_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe,
              "R1 pins in reset", {sram_cs_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready in idle", req_ready, 1);

        // Vector table: writes, reads, turnarounds
        for (int i = 0; i < NOPS; i++) issue(OPS[i][23], OPS[i][22:8], OPS[i][7:0]);
        drain();
        check(rd_idx == 5, "R9 one response per read", rd_idx, 5);

        // R10/R2 latency from idle
        issue(1'b0, 15'h0040, 8'h40 ^ 8'h5A);
        n = 0;
        check(!sram_cs_n && sram_ce && sram_we_n && !sram_oe_n && sram_addr == 15'h0040,
              "R2 read strobes", {sram_cs_n, sram_ce, sram_we_n, sram_oe_n}, 4'b0110);
        check(req_ready == 1'b0, "R8 ready low in read wait", req_ready, 0);
        do begin @(negedge clk); n++; end while (!rsp_valid && n < 20);
        check(n == RD_EXP + 1, "R10 read response cycle", n, RD_EXP + 1);
        drain();

        // R6 back-to-back reads
        issue(1'b0, 15'h0021, 8'h21 ^ 8'h5A);
        snap = cs_rise;
        issue(1'b0, 15'h0022, 8'h22 ^ 8'h5A);
        @(negedge clk);
        check(cs_rise == snap && !sram_cs_n && !sram_oe_n && sram_addr == 15'h0022,
              "R6 select held across reads", cs_rise - snap, 0);
        drain();
        check(sram_cs_n && !sram_ce, "R1 deselect after access", {sram_cs_n, sram_ce}, 2'b10);

        // R8 inputs ignored without valid
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            req_write = k[0]; req_addr = 15'(k * 7); req_wdata = 8'(k);
            @(negedge clk);
            if (!sram_cs_n || sram_ce || !sram_we_n || !sram_oe_n || sram_dq_oe || rsp_valid) bad++;
        end
        check(bad == 0, "R8 idle inputs ignored", bad, 0);

        check(turn_err == 0, "R7 bus turnaround", turn_err, 0);
        check(pw_err == 0, "R3/R10 write pulse width", pw_err, 0);
        check(pulses == 4, "R3 pulse count", pulses, 4);
        check(gap_err == 0, "R5 gap between writes", gap_err, 0);
        check(stab_err == 0, "R4 address/data hold", stab_err, 0);
        check(rsp_err == 0, "R9 response pulse", rsp_err, 0);
        finished = 1;
        summary();
    end
endmodule